// File: doc/BRIEF.md
# Capture/Reload Up-Down Timer with Clock-Out

This block is a 16-bit timer/counter paired with a 16-bit reload/capture register. Software sets a control byte and the counter and reload values through a single write port. The block then runs in one of four modes. In plain auto-reload mode it counts up and loads the reload value on overflow. In capture mode it copies the counter into the reload register when a falling trigger edge arrives. In up/down mode the trigger pin sets the direction. In baud-generator mode it emits one overflow pulse per period for a serial clock divider.

The counting source is one of two. In timer function it is a machine-cycle tick, or every clock in the fast modes. In counter function it is the falling edges of an external count pin. A clock-out option toggles a pin on every overflow, which gives a square wave with 50% duty.

Top module: `crt_timer`

## Requirements
- R1: After reset, count, reload, control, both flags, the interrupt request, the baud pulse and the clock-out pin are all 0.
- R2: A write with wr_sel=0 loads the control byte, wr_sel=1 loads the counter and wr_sel=2 loads the reload register. The values read back on ctrl_o, count_o and reload_o. A counter write takes priority over a count step in the same cycle.
- R3: Control bits are: bit0 run, bit1 counter function, bit2 capture select, bit3 trigger enable, bit4 and bit5 the two serial clock selects, bit6 up/down enable, bit7 clock-out enable. In auto-reload timer function each mc_tick while run=1 adds one. A step from all-ones loads the reload value and sets ovf_flag_o.
- R4: In up/down mode (bit6=1, bit2=0, no serial select), trig_in=1 counts up. A step from all-ones loads the reload value. trig_in=0 counts down, and a step while the count equals the reload value loads all-ones. Either wrap sets ovf_flag_o and toggles ext_flag_o.
- R5: In up/down mode ext_flag_o never drives irq_o, a falling trigger edge changes neither the flag nor the count, and irq_o equals ovf_flag_o.
- R6: When either serial select bit is 1, capture select is ignored. The count advances every clock while run=1. An overflow loads the reload value, leaves ovf_flag_o unchanged and gives baud_pulse_o for exactly one cycle.
- R7: In baud mode with trigger enable set, a falling edge of trig_in sets ext_flag_o and irq_o.
- R8: In auto-reload mode with trigger enable set, a falling edge of trig_in loads the reload value into the counter and sets ext_flag_o.
- R9: In capture mode with trigger enable set, a falling edge copies the count into the reload register and sets ext_flag_o. An overflow wraps the count to 0 and sets ovf_flag_o, and both can happen in one cycle.
- R10: With clock-out enable set and timer function, the count advances every clock and each overflow toggles clk_out_o. In counter function clk_out_o holds.
- R11: With counter function set, each falling edge of cnt_in is one step and mc_tick has no effect.
- R12: A write with wr_sel=3 clears ovf_flag_o when wr_data bit0=1 and clears ext_flag_o when bit1=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 counter, 2 reload, 3 flag clear |
| wr_data | input | W | Write data |
| trig_in | input | 1 | External trigger / direction pin (asynchronous) |
| cnt_in | input | 1 | External count pin (asynchronous) |
| mc_tick | input | 1 | Machine-cycle tick for timer function |
| ctrl_o | output | 8 | Control byte |
| count_o | output | W | Counter value |
| reload_o | output | W | Reload/capture register |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External flag |
| irq_o | output | 1 | Interrupt request |
| baud_pulse_o | output | 1 | One-cycle overflow pulse in baud mode |
| clk_out_o | output | 1 | Clock-out pin |

## Verification
In capture mode a synchronized falling trigger edge and a counter overflow can land on the same clock edge. The capture must then take the count from before the wrap, while the counter goes to zero. The bench provokes this by setting the count to all-ones and dropping trig_in. It then raises mc_tick for the single cycle in which the synchronizer presents the edge, counted from the two synchronizing stages plus the edge register. The result is judged by the reload register holding all-ones, the counter holding zero, and both flags set.

// File: rtl/crt_pkg.sv
package crt_pkg;

  typedef enum logic [1:0] {
    MODE_RELOAD  = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_UPDOWN  = 2'd2,
    MODE_BAUD    = 2'd3
  } crt_mode_e;

  // packed MSB first: bit7 .. bit0
  typedef struct packed {
    logic clkout_en;
    logic updown_en;
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic cap_sel;
    logic cnt_sel;
    logic run;
  } crt_ctrl_t;

  localparam int CTRL_W = $bits(crt_ctrl_t);

  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_COUNT  = 2'd1;
  localparam logic [1:0] SEL_RELOAD = 2'd2;
  localparam logic [1:0] SEL_FLAGS  = 2'd3;

  function automatic crt_mode_e crt_decode(input crt_ctrl_t c);
    if (c.tx_sel || c.rx_sel) return MODE_BAUD;
    else if (c.cap_sel)       return MODE_CAPTURE;
    else if (c.updown_en)     return MODE_UPDOWN;
    else                      return MODE_RELOAD;
  endfunction

endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic level_d
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign level   = sh[STAGES-1];
  assign level_d = sh[STAGES];
endmodule

// File: rtl/crt_counter.sv
module crt_counter import crt_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  crt_mode_e    mode,
  input  logic         step,
  input  logic         dir_up,
  input  logic         trig_load,
  input  logic         wr_count,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         ovf_evt
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic at_top, at_floor, wrap, counting_down;
  logic [W-1:0] count_nx;

  assign at_top        = (count == ALL_ONES);
  assign at_floor      = (count == reload);
  assign counting_down = (mode == MODE_UPDOWN) && !dir_up;
  assign wrap          = counting_down ? at_floor : at_top;
  assign ovf_evt       = step && !wr_count && !trig_load && wrap;

  always_comb begin
    count_nx = count;
    if (wr_count) begin
      count_nx = wr_data;
    end else if (trig_load) begin
      count_nx = reload;
    end else if (step) begin
      unique case (mode)
        MODE_CAPTURE: count_nx = count + 1'b1;
        MODE_UPDOWN: begin
          if (dir_up) count_nx = at_top ? reload : count + 1'b1;
          else        count_nx = at_floor ? ALL_ONES : count - 1'b1;
        end
        default:      count_nx = at_top ? reload : count + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_nx;
  end
endmodule

// File: rtl/crt_status.sv
module crt_status import crt_pkg::*; (
  input  logic      clk,
  input  logic      rst,
  input  crt_mode_e mode,
  input  logic      clkout_act,
  input  logic      ovf_evt,
  input  logic      ext_set,
  input  logic      clr_ovf,
  input  logic      clr_ext,
  output logic      ovf_flag,
  output logic      ext_flag,
  output logic      baud_pulse,
  output logic      clk_out
);
  logic is_baud, is_updown;

  assign is_baud   = (mode == MODE_BAUD);
  assign is_updown = (mode == MODE_UPDOWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag   <= 1'b0;
      ext_flag   <= 1'b0;
      baud_pulse <= 1'b0;
      clk_out    <= 1'b0;
    end else begin
      // hardware set wins over a software clear
      if (ovf_evt && !is_baud) ovf_flag <= 1'b1;
      else if (clr_ovf)        ovf_flag <= 1'b0;

      if (ovf_evt && is_updown) ext_flag <= ~ext_flag;
      else if (ext_set)         ext_flag <= 1'b1;
      else if (clr_ext)         ext_flag <= 1'b0;

      baud_pulse <= ovf_evt && is_baud;

      if (ovf_evt && clkout_act) clk_out <= ~clk_out;
    end
  end
endmodule

// File: rtl/crt_timer.sv
module crt_timer import crt_pkg::*; #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [W-1:0]      wr_data,
  input  logic              trig_in,
  input  logic              cnt_in,
  input  logic              mc_tick,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [W-1:0]      count_o,
  output logic [W-1:0]      reload_o,
  output logic              ovf_flag_o,
  output logic              ext_flag_o,
  output logic              irq_o,
  output logic              baud_pulse_o,
  output logic              clk_out_o
);
  localparam int NPIN = 2;
  localparam int PIN_TRIG = 0;
  localparam int PIN_CNT  = 1;

  crt_ctrl_t    ctrl_q;
  logic [W-1:0] reload_q;
  logic [W-1:0] count_q;
  crt_mode_e    mode;

  logic wr_ctrl, wr_count, wr_reload, wr_flags;
  assign wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
  assign wr_count  = wr_en && (wr_sel == SEL_COUNT);
  assign wr_reload = wr_en && (wr_sel == SEL_RELOAD);
  assign wr_flags  = wr_en && (wr_sel == SEL_FLAGS);

  // pin synchronizers
  logic [NPIN-1:0] pin_raw, pin_lvl, pin_lvl_d, pin_fall;
  assign pin_raw[PIN_TRIG] = trig_in;
  assign pin_raw[PIN_CNT]  = cnt_in;

  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    crt_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst     (rst),
      .din     (pin_raw[i]),
      .level   (pin_lvl[i]),
      .level_d (pin_lvl_d[i])
    );
    assign pin_fall[i] = pin_lvl_d[i] && !pin_lvl[i];
  end

  assign mode = crt_decode(ctrl_q);

  // step source
  logic fast, step, clkout_act;
  assign clkout_act = ctrl_q.clkout_en && !ctrl_q.cnt_sel;
  assign fast       = !ctrl_q.cnt_sel && (ctrl_q.tx_sel || ctrl_q.rx_sel || ctrl_q.clkout_en);
  assign step       = ctrl_q.run &&
                      (ctrl_q.cnt_sel ? pin_fall[PIN_CNT] : (fast || mc_tick));

  // trigger actions
  logic trig_ev, trig_load, cap_evt, ext_set, ovf_evt;
  assign trig_ev   = ctrl_q.ext_en && pin_fall[PIN_TRIG];
  assign trig_load = trig_ev && (mode == MODE_RELOAD);
  assign cap_evt   = trig_ev && (mode == MODE_CAPTURE);
  assign ext_set   = trig_ev && (mode != MODE_UPDOWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= crt_ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_reload)    reload_q <= wr_data;
      else if (cap_evt) reload_q <= count_q;
    end
  end

  crt_counter #(.W(W)) counter_i (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .step      (step),
    .dir_up    (pin_lvl[PIN_TRIG]),
    .trig_load (trig_load),
    .wr_count  (wr_count),
    .wr_data   (wr_data),
    .reload    (reload_q),
    .count     (count_q),
    .ovf_evt   (ovf_evt)
  );

  logic ovf_flag, ext_flag;

  crt_status status_i (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .clkout_act (clkout_act),
    .ovf_evt    (ovf_evt),
    .ext_set    (ext_set),
    .clr_ovf    (wr_flags && wr_data[0]),
    .clr_ext    (wr_flags && wr_data[1]),
    .ovf_flag   (ovf_flag),
    .ext_flag   (ext_flag),
    .baud_pulse (baud_pulse_o),
    .clk_out    (clk_out_o)
  );

  assign ctrl_o     = ctrl_q;
  assign count_o    = count_q;
  assign reload_o   = reload_q;
  assign ovf_flag_o = ovf_flag;
  assign ext_flag_o = ext_flag;
  assign irq_o      = ovf_flag || (ext_flag && (mode != MODE_UPDOWN));
endmodule

// File: rtl/crt_timer_chk.sv
module crt_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [W-1:0] wr_data,
  input logic [7:0]   ctrl_bits,
  input logic [W-1:0] count_o,
  input logic [W-1:0] reload_o,
  input logic         ovf_flag_o,
  input logic         baud_pulse_o,
  input logic         clk_out_o
);
  logic baud_sel;
  assign baud_sel = ctrl_bits[4] || ctrl_bits[5];

  // R6: baud mode never raises the overflow flag
  a_r6_baud_no_ovf: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag_o) |-> !$past(baud_sel));

  // R6: baud pulse only follows a cycle in baud mode
  a_r6_pulse_src: assert property (@(posedge clk) disable iff (rst)
    baud_pulse_o |-> $past(baud_sel));

  // R10: clock-out moves only with clock-out enabled in timer function
  a_r10_clkout_gate: assert property (@(posedge clk) disable iff (rst)
    (!$stable(clk_out_o) && $past(!rst)) |-> $past(ctrl_bits[7] && !ctrl_bits[1]));

  // R2: counter write wins
  a_r2_count_write: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr_en && wr_sel == 2'd1)) |-> count_o == $past(wr_data));

  // R9: reload register changes only by write or capture
  a_r9_reload_src: assert property (@(posedge clk) disable iff (rst)
    (!$stable(reload_o) && $past(!rst)) |->
      ($past(wr_en && wr_sel == 2'd2) ||
       $past(ctrl_bits[2] && ctrl_bits[3] && !baud_sel)));
endmodule

bind crt_timer crt_timer_chk #(.W(W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .ctrl_bits    (ctrl_o),
  .count_o      (count_o),
  .reload_o     (reload_o),
  .ovf_flag_o   (ovf_flag_o),
  .baud_pulse_o (baud_pulse_o),
  .clk_out_o    (clk_out_o)
);

// File: tb/crt_timer_tb_top.sv
`timescale 1ns/1ps
module crt_timer_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         trig_in = 1'b1;
  logic         cnt_in = 1'b1;
  logic         mc_tick = 1'b0;
  logic [7:0]   ctrl_o;
  logic [W-1:0] count_o, reload_o;
  logic         ovf_flag_o, ext_flag_o, irq_o, baud_pulse_o, clk_out_o;

  int checks = 0;
  int errors = 0;
  int pulse_cnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  crt_timer #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .trig_in(trig_in), .cnt_in(cnt_in), .mc_tick(mc_tick),
    .ctrl_o(ctrl_o), .count_o(count_o), .reload_o(reload_o),
    .ovf_flag_o(ovf_flag_o), .ext_flag_o(ext_flag_o), .irq_o(irq_o),
    .baud_pulse_o(baud_pulse_o), .clk_out_o(clk_out_o)
  );

  always @(negedge clk) if (baud_pulse_o) pulse_cnt <= pulse_cnt + 1;

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); mc_tick = 1'b1;
    @(negedge clk); mc_tick = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_trig(input logic v);
    @(negedge clk); trig_in = v;
    settle(4);
  endtask

  task automatic prep();
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0003);
  endtask

  task automatic t_reset();
    chk("R1", "count", count_o, 16'h0000);
    chk("R1", "reload", reload_o, 16'h0000);
    chk("R1", "ctrl", {8'h00, ctrl_o}, 16'h0000);
    chk("R1", "flags/irq/pulse/clkout",
        {11'd0, ovf_flag_o, ext_flag_o, irq_o, baud_pulse_o, clk_out_o}, 16'h0000);
  endtask

  task automatic t_regs();
    wr(2'd2, 16'hABCD);
    chk("R2", "reload readback", reload_o, 16'hABCD);
    wr(2'd0, 16'h0001);
    chk("R2", "ctrl readback", {8'h00, ctrl_o}, 16'h0001);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h0050; mc_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; mc_tick = 1'b0;
    chk("R2", "write beats step", count_o, 16'h0050);
    tick();
    chk("R3", "tick increments", count_o, 16'h0051);
  endtask

  task automatic t_reload();
    prep();
    wr(2'd2, 16'hFFF0);
    wr(2'd1, 16'hFFFE);
    wr(2'd0, 16'h0001);
    tick();
    chk("R3", "count before wrap", count_o, 16'hFFFF);
    chk("R3", "no flag yet", {15'd0, ovf_flag_o}, 16'h0000);
    tick();
    chk("R3", "reload on wrap", count_o, 16'hFFF0);
    chk("R3", "ovf and irq", {14'd0, ovf_flag_o, irq_o}, 16'h0003);
    wr(2'd3, 16'h0001);
    chk("R12", "ovf cleared", {14'd0, ovf_flag_o, irq_o}, 16'h0000);
  endtask

  task automatic t_updown();
    prep();
    wr(2'd2, 16'h1000);
    wr(2'd1, 16'hFFFF);
    wr(2'd0, 16'h0049);
    settle(4);
    tick();
    chk("R4", "up wrap reloads", count_o, 16'h1000);
    chk("R4", "ovf set, ext toggled", {14'd0, ovf_flag_o, ext_flag_o}, 16'h0003);
    wr(2'd3, 16'h0001);
    chk("R5", "ext alone gives no irq", {14'd0, ext_flag_o, irq_o}, 16'h0002);
    wr(2'd3, 16'h0002);
    chk("R12", "ext cleared", {15'd0, ext_flag_o}, 16'h0000);
    set_trig(1'b0);
    chk("R5", "falling edge ignored (flag)", {15'd0, ext_flag_o}, 16'h0000);
    chk("R5", "falling edge ignored (count)", count_o, 16'h1000);
    wr(2'd1, 16'h1002);
    tick(); tick();
    chk("R4", "down count", count_o, 16'h1000);
    chk("R4", "no flag before floor", {15'd0, ovf_flag_o}, 16'h0000);
    tick();
    chk("R4", "floor loads all-ones", count_o, 16'hFFFF);
    chk("R4", "ovf set, ext toggled", {14'd0, ovf_flag_o, ext_flag_o}, 16'h0003);
    tick();
    chk("R4", "keeps counting down", count_o, 16'hFFFE);
  endtask

  task automatic t_baud();
    int p0;
    prep();
    set_trig(1'b1);
    wr(2'd2, 16'hFF00);
    wr(2'd1, 16'hFFFE);
    p0 = pulse_cnt;
    wr(2'd0, 16'h001D);   // run, capture select, trigger enable, serial select
    settle(8);
    wr(2'd0, 16'h001C);   // stop: 10 steps taken
    settle(2);
    chk("R6", "reload path, capture ignored", count_o, 16'hFF08);
    chk("R6", "reload reg untouched", reload_o, 16'hFF00);
    chk("R6", "no ovf flag", {15'd0, ovf_flag_o}, 16'h0000);
    chk("R6", "one single-cycle pulse", 16'(pulse_cnt - p0), 16'h0001);
    set_trig(1'b0);
    chk("R7", "ext and irq on falling edge", {14'd0, ext_flag_o, irq_o}, 16'h0003);
  endtask

  task automatic t_trig_reload();
    prep();
    set_trig(1'b1);
    wr(2'd2, 16'h4000);
    wr(2'd1, 16'h0123);
    wr(2'd0, 16'h0009);
    set_trig(1'b0);
    chk("R8", "edge reloads count", count_o, 16'h4000);
    chk("R8", "ext set, ovf clear", {14'd0, ovf_flag_o, ext_flag_o}, 16'h0001);
  endtask

  task automatic t_capture();
    prep();
    set_trig(1'b1);
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h1234);
    wr(2'd0, 16'h000D);
    set_trig(1'b0);
    chk("R9", "capture copies count", reload_o, 16'h1234);
    chk("R9", "count unchanged", count_o, 16'h1234);
    chk("R9", "ext set", {15'd0, ext_flag_o}, 16'h0001);
    wr(2'd3, 16'h0003);
    set_trig(1'b1);
    wr(2'd1, 16'hFFFF);
    // edge reaches the logic on the third rising edge after the pin drops
    @(negedge clk); trig_in = 1'b0;
    @(negedge clk);
    @(negedge clk); mc_tick = 1'b1;
    @(negedge clk); mc_tick = 1'b0;
    settle(2);
    chk("R9", "same-cycle: wrap to zero", count_o, 16'h0000);
    chk("R9", "same-cycle: captured pre-wrap", reload_o, 16'hFFFF);
    chk("R9", "same-cycle: both flags", {14'd0, ovf_flag_o, ext_flag_o}, 16'h0003);
  endtask

  task automatic t_clkout();
    prep();
    wr(2'd2, 16'hFFFC);
    wr(2'd1, 16'hFFFC);
    wr(2'd0, 16'h0081);
    settle(10);
    wr(2'd0, 16'h0080);   // 12 steps, 3 wraps
    chk("R10", "count after 3 wraps", count_o, 16'hFFFC);
    chk("R10", "pin toggled 3 times", {15'd0, clk_out_o}, 16'h0001);
    chk("R10", "ovf set", {15'd0, ovf_flag_o}, 16'h0001);
    wr(2'd0, 16'h0083);
    wr(2'd1, 16'hFFFF);
    tick();
    chk("R11", "mc_tick ignored", count_o, 16'hFFFF);
    @(negedge clk); cnt_in = 1'b0; settle(4);
    @(negedge clk); cnt_in = 1'b1; settle(4);
    chk("R11", "edge wraps counter", count_o, 16'hFFFC);
    chk("R10", "pin holds in counter function", {15'd0, clk_out_o}, 16'h0001);
    @(negedge clk); cnt_in = 1'b0; settle(4);
    chk("R11", "second edge counts", count_o, 16'hFFFD);
  endtask

  initial begin
    settle(3);
    rst = 1'b0;
    settle(1);
    t_reset();
    t_regs();
    t_reload();
    t_updown();
    t_baud();
    t_trig_reload();
    t_capture();
    t_clkout();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule